// File: doc/BRIEF.md
# Two-Level Interrupt Enable Combiner

This block decides whether a multi-stream audio controller raises its single interrupt line. It takes eight per-stream status lines (four capture streams, four playback streams), three controller-level event lines and a bus-level interrupt enable. It folds them through a two-level mask held in one 32-bit control register. The register sits at byte offset 0x20 of a small register bus. A read of that offset returns the register combinationally, in the same cycle as the read strobe.

The top of the mask is a master enable, which works together with the bus-level enable input. Below it sit two groups. The first is one enable covering all three controller events. The second is one enable per stream.

The output is registered and level-sensitive. It follows its inputs one clock later and drops once the contributing status lines fall. A one-cycle pulse marking the return from the low-power hot state to full operation leaves every enable bit untouched. Only the synchronous reset clears the register.

Top module: `irq_gate_ctrl`

## Requirements
- R1: Synchronous reset clears the control register to 0x00000000 and drives `irq_out` low.
- R2: A write to offset 0x20 stores bits 31, 30 and 7:0. The bits in 29:8 read back as 0 whatever was written.
- R3: A read of any offset other than 0x20 returns 0, and a write to any other offset leaves the control register unchanged.
- R4: `rdata` carries the register value in the same cycle that `rd_en` is high with offset 0x20, and is 0 when `rd_en` is low.
- R5: With bit 31 (master enable) at 0, `irq_out` stays low for every status pattern.
- R6: With `bus_irq_en` low, `irq_out` stays low for every register value and status pattern.
- R7: With bits 31 and 30 set, any one of `ctrl_sts[0]` (response interrupt), `ctrl_sts[1]` (response buffer overrun) or `ctrl_sts[2]` (state change) raises `irq_out`. With bit 30 clear, these events have no effect.
- R8: Bit k, for k = 0 to 3, enables `in_stream_sts[k]` (capture stream k+1). Bit k+4 enables `out_stream_sts[k]` (playback stream k+1). A status line whose enable is 0 does not raise `irq_out`.
- R9: `irq_out` is registered. It reflects the inputs and the register value of the previous clock, and it falls one clock after the contributing status lines fall.
- R10: A `pm_wake` pulse without a write leaves all enable bits, bits 31 and 30 included, at their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the strobe cycle |
| in_stream_sts | input | 4 | Capture stream status lines, index k = stream k+1 |
| out_stream_sts | input | 4 | Playback stream status lines, index k = stream k+1 |
| ctrl_sts | input | 3 | Controller events: 0 response interrupt, 1 response overrun, 2 state change |
| bus_irq_en | input | 1 | Bus-level interrupt enable |
| pm_wake | input | 1 | One-cycle pulse on return to the active power state |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume the inputs are synchronous to `clk`. They also assume `pm_wake` is a pulse of exactly one cycle, and that status lines are steady levels that the upstream per-source masking has already qualified. The bench changes every input at the falling edge. It raises `pm_wake` for a single cycle only, and it holds each status pattern for at least two rising edges, so that the registered output settles before it is sampled.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned CTL_W     = 32;
  localparam int unsigned BIT_MASTER = 31;
  localparam int unsigned BIT_GROUP  = 30;
  localparam int unsigned N_IN      = 4;
  localparam int unsigned N_OUT     = 4;
  localparam int unsigned N_EVT     = 3;

  typedef enum logic [1:0] {
    EVT_RESP   = 2'd0,
    EVT_OVRUN  = 2'd1,
    EVT_STCHG  = 2'd2
  } evt_idx_e;
endpackage

// File: rtl/irq_gate_regs.sv
module irq_gate_regs #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_STREAM = 8,
  parameter int unsigned B_MASTER = 31,
  parameter int unsigned B_GROUP  = 30,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                pm_wake,
  output logic [DATA_W-1:0]   rdata,
  output logic                master_en,
  output logic                group_en,
  output logic [N_STREAM-1:0] stream_en
);
  localparam logic [DATA_W-1:0] STREAM_MASK =
    {{(DATA_W-N_STREAM){1'b0}}, {N_STREAM{1'b1}}};
  localparam logic [DATA_W-1:0] LIVE_MASK = STREAM_MASK
    | (DATA_W'(1) << B_MASTER) | (DATA_W'(1) << B_GROUP);

  logic hit;
  logic wr_hit;
  logic [DATA_W-1:0] view;

  assign hit    = (addr == OFFSET);
  assign wr_hit = wr_en && hit;

  // Top two enables: only the main reset clears them; pm_wake is not a clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      master_en <= 1'b0;
      group_en  <= 1'b0;
    end else if (wr_hit) begin
      master_en <= wdata[B_MASTER];
      group_en  <= wdata[B_GROUP];
    end
  end

  // One flop per stream enable
  for (genvar s = 0; s < N_STREAM; s++) begin : g_sen
    always_ff @(posedge clk) begin
      if (rst)         stream_en[s] <= 1'b0;
      else if (wr_hit) stream_en[s] <= wdata[s];
    end
  end

  always_comb begin
    view = '0;
    view[N_STREAM-1:0] = stream_en;
    view[B_MASTER]     = master_en;
    view[B_GROUP]      = group_en;
  end

  assign rdata = (rd_en && hit) ? view : '0;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (view == '0)); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~LIVE_MASK) == '0); // R2
  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!(rd_en && hit)) |-> (rdata == '0)); // R3
  AST_MISS_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit) |=> $stable(view)); // R3
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pm_wake && !wr_hit) |=> $stable(view)); // R10
endmodule

// File: rtl/irq_gate_combine.sv
module irq_gate_combine #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_OUT = 4,
  parameter int unsigned N_EVT = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_en,
  input  logic                   master_en,
  input  logic                   group_en,
  input  logic [N_IN+N_OUT-1:0]  stream_en,
  input  logic [N_IN-1:0]        in_sts,
  input  logic [N_OUT-1:0]       out_sts,
  input  logic [N_EVT-1:0]       evt_sts,
  output logic                   irq_q
);
  localparam int unsigned N_STREAM = N_IN + N_OUT;

  logic [N_STREAM-1:0] sts_all;
  logic [N_STREAM-1:0] hit_vec;
  logic evt_any;
  logic stream_any;
  logic irq_d;

  // Register order: capture streams in the low bits, playback above them
  assign sts_all = {out_sts, in_sts};

  for (genvar s = 0; s < N_STREAM; s++) begin : g_and
    assign hit_vec[s] = stream_en[s] & sts_all[s];
  end

  assign evt_any    = group_en & (|evt_sts);
  assign stream_any = |hit_vec;
  assign irq_d      = bus_en & master_en & (evt_any | stream_any);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> !irq_q); // R5
  AST_BUS_GATE: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> !irq_q); // R6
  AST_EVT_RAISE: assert property (@(posedge clk) disable iff (rst)
    (bus_en && master_en && group_en && (evt_sts != '0)) |=> irq_q); // R7
  AST_IN1_ORDER: assert property (@(posedge clk) disable iff (rst)
    (bus_en && master_en && stream_en[0] && in_sts[0]) |=> irq_q); // R8
  AST_OUT1_ORDER: assert property (@(posedge clk) disable iff (rst)
    (bus_en && master_en && stream_en[N_IN] && out_sts[0]) |=> irq_q); // R8
  AST_QUIET_DROP: assert property (@(posedge clk) disable iff (rst)
    ((evt_sts == '0) && (in_sts == '0) && (out_sts == '0)) |=> !irq_q); // R9
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CTL_W-1:0]   wdata,
  output logic [CTL_W-1:0]   rdata,
  input  logic [N_IN-1:0]    in_stream_sts,
  input  logic [N_OUT-1:0]   out_stream_sts,
  input  logic [N_EVT-1:0]   ctrl_sts,
  input  logic               bus_irq_en,
  input  logic               pm_wake,
  output logic               irq_out
);
  localparam int unsigned N_STREAM = N_IN + N_OUT;

  logic                master_en;
  logic                group_en;
  logic [N_STREAM-1:0] stream_en;

  irq_gate_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (CTL_W),
    .N_STREAM (N_STREAM),
    .B_MASTER (BIT_MASTER),
    .B_GROUP  (BIT_GROUP),
    .OFFSET   (OFFSET)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .pm_wake   (pm_wake),
    .rdata     (rdata),
    .master_en (master_en),
    .group_en  (group_en),
    .stream_en (stream_en)
  );

  irq_gate_combine #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT),
    .N_EVT (N_EVT)
  ) comb_i (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_irq_en),
    .master_en (master_en),
    .group_en  (group_en),
    .stream_en (stream_en),
    .in_sts    (in_stream_sts),
    .out_sts   (out_stream_sts),
    .evt_sts   (ctrl_sts),
    .irq_q     (irq_out)
  );

  AST_RESET_IRQ_LOW: assert property (@(posedge clk)
    rst |=> !irq_out); // R1
endmodule

// File: tb/irq_gate_ctrl_tb_top.sv
module irq_gate_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, bus_irq_en = 1'b0, pm_wake = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  in_stream_sts = '0, out_stream_sts = '0;
  logic [2:0]  ctrl_sts = '0;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_gate_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .in_stream_sts(in_stream_sts),
    .out_stream_sts(out_stream_sts), .ctrl_sts(ctrl_sts),
    .bus_irq_en(bus_irq_en), .pm_wake(pm_wake), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [31:0] ctl;
    logic        bus;
    logic [2:0]  cs;
    logic [3:0]  is;
    logic [3:0]  os;
    logic        exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{32'hC0000000, 1'b1, 3'b001, 4'h0, 4'h0, 1'b1, 4'd7}, // R7 response
    '{32'hC0000000, 1'b1, 3'b010, 4'h0, 4'h0, 1'b1, 4'd7}, // R7 overrun
    '{32'hC0000000, 1'b1, 3'b100, 4'h0, 4'h0, 1'b1, 4'd7}, // R7 state change
    '{32'h80000000, 1'b1, 3'b111, 4'h0, 4'h0, 1'b0, 4'd7}, // R7 group off
    '{32'h40000000, 1'b1, 3'b111, 4'h0, 4'h0, 1'b0, 4'd5}, // R5 master off
    '{32'hC00000FF, 1'b0, 3'b111, 4'hF, 4'hF, 1'b0, 4'd6}, // R6 bus off
    '{32'h80000001, 1'b1, 3'b000, 4'h1, 4'h0, 1'b1, 4'd8}, // R8 in1
    '{32'h80000001, 1'b1, 3'b000, 4'h2, 4'h0, 1'b0, 4'd8}, // R8 in2 masked
    '{32'h80000010, 1'b1, 3'b000, 4'h0, 4'h1, 1'b1, 4'd8}, // R8 out1
    '{32'h80000010, 1'b1, 3'b000, 4'h1, 4'h0, 1'b0, 4'd8}, // R8 in1 masked
    '{32'h80000080, 1'b1, 3'b000, 4'h0, 4'h8, 1'b1, 4'd8}, // R8 out4
    '{32'h80000008, 1'b1, 3'b000, 4'h8, 4'h0, 1'b1, 4'd8}, // R8 in4
    '{32'h800000F0, 1'b1, 3'b000, 4'hF, 4'h0, 1'b0, 4'd8}, // R8 inputs masked
    '{32'h000000FF, 1'b1, 3'b111, 4'hF, 4'hF, 1'b0, 4'd5}, // R5 master off
    '{32'hC00000FF, 1'b1, 3'b000, 4'h0, 4'h0, 1'b0, 4'd9}  // R9 no status
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    do_read(8'h20, rd);
    check("R1 reg after reset", rd, 32'h0);
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

    // R2 reserved bits
    do_write(8'h20, 32'hFFFFFFFF);
    do_read(8'h20, rd);
    check("R2 reserved read zero", rd, 32'hC00000FF);

    // R3 other offsets
    do_write(8'h24, 32'h00000000);
    do_read(8'h20, rd);
    check("R3 write elsewhere ignored", rd, 32'hC00000FF);
    do_read(8'h24, rd);
    check("R3 read elsewhere zero", rd, 32'h0);

    // R4 read strobe timing
    @(negedge clk);
    addr = 8'h20; rd_en = 1'b0;
    #1 check("R4 no strobe zero", rdata, 32'h0);
    rd_en = 1'b1;
    #1 check("R4 same-cycle data", rdata, 32'hC00000FF);
    rd_en = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      do_write(8'h20, VEC[i].ctl);
      bus_irq_en = VEC[i].bus; ctrl_sts = VEC[i].cs;
      in_stream_sts = VEC[i].is; out_stream_sts = VEC[i].os;
      @(negedge clk);
      @(negedge clk);
      check(rname(VEC[i].rq), {31'b0, irq_out}, {31'b0, VEC[i].exp});
      do_read(8'h20, rd);
      check("R2 readback", rd, VEC[i].ctl & 32'hC00000FF);
    end

    // R9 latency and level behaviour
    do_write(8'h20, 32'hC0000000);
    bus_irq_en = 1'b1; ctrl_sts = '0; in_stream_sts = '0; out_stream_sts = '0;
    @(negedge clk); @(negedge clk);
    ctrl_sts = 3'b001;
    #1 check("R9 no change before edge", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R9 rise after one edge", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    check("R9 level held", {31'b0, irq_out}, 32'h1);
    ctrl_sts = '0;
    @(negedge clk);
    check("R9 falls after status clears", {31'b0, irq_out}, 32'h0);

    // R10 wake pulse holds enables
    do_write(8'h20, 32'hC00000A5);
    ctrl_sts = 3'b100;
    @(negedge clk);
    pm_wake = 1'b1;
    @(negedge clk);
    pm_wake = 1'b0;
    do_read(8'h20, rd);
    check("R10 enables kept", rd, 32'hC00000A5);
    @(negedge clk);
    check("R10 irq kept", {31'b0, irq_out}, 32'h1);

    // R1 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq after late reset", {31'b0, irq_out}, 32'h0);
    do_read(8'h20, rd);
    check("R1 reg after late reset", rd, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule